// File: doc/BRIEF.md
# Way-Predicted Cache Lookup Unit

This unit is the lookup stage of a set-associative first-level cache with many ways. It guesses which way holds the requested line and drives that way's data out before the full tag comparison has finished. A comparison of every way runs alongside the guess and either confirms it or overrules it. A confirmed guess answers in the first cycle after the request is accepted. A wrong guess raises `stall` for one cycle, and the correct way's data follows in the next cycle. A request that matches no way returns a miss at once, with no stall.

Each request chooses one of two guessing modes. In history mode a table holds the way that last hit for each entry. The entry is picked by the set index XORed with low program-counter bits, and every hit writes the hitting way back into it. In partial-tag mode the lowest four tag bits of each valid way are compared with the request, and the lowest-numbered match steers the data mux. A small fill port loads tags and data so that the stage has contents to search. Three counters report confirmed guesses, wrong guesses and misses.

Top module: `wp_lookup`

## Requirements
- R1: After a synchronous active-low reset, `resp_valid` and `stall` are 0, all three counters read 0, no way is valid and every history entry predicts way 0.
- R2: A request accepted at a clock edge whose guessed way is the hitting way gives `resp_valid`=1, `resp_hit`=1, `stall`=0 and that way's data in the cycle that follows the edge.
- R3: When the guessed way differs from the hitting way, the first cycle shows `stall`=1 and `resp_valid`=0. The next cycle shows `resp_valid`=1, `resp_hit`=1, `stall`=0 and the hitting way's data.
- R4: When no valid way matches the full tag, the first cycle shows `resp_valid`=1, `resp_hit`=0 and `stall`=0.
- R5: In history mode (`req_mode`=0) the guess is the table entry at index (set XOR `req_pc`). Every hit, whether guessed right or wrong and in either mode, writes the hitting way into that entry.
- R6: In partial-tag mode (`req_mode`=1) the guess is the lowest-numbered valid way whose tag bits [3:0] equal the request's tag bits [3:0]. When no valid way matches, the guess is way 0.
- R7: `cnt_pred_hit`, `cnt_mispred` and `cnt_miss` each increase by one, at the edge that ends the first cycle, for a correct guess, a wrong guess and a miss respectively.
- R8: Request inputs presented while `stall` is 1 are not accepted. The replay answers the stalled request, and nothing else is answered afterward unless a request is presented again.
- R9: A fill with `fill_en`=1 writes the tag (`fill_addr` bits above the index), data and valid flag of way `fill_way` in set `fill_addr[IDX_W-1:0]`, replacing what was there.
- R10: In the first cycle, `resp_data` carries the guessed way's data, including on a miss and on a wrong guess.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | TAG_W+IDX_W | Line address, {tag, set index} |
| req_pc | input | IDX_W | Low program-counter bits used to hash the history index |
| req_mode | input | 1 | 0 = history guess, 1 = partial-tag guess |
| fill_en | input | 1 | Write one way of one set |
| fill_addr | input | TAG_W+IDX_W | Line address being filled, {tag, set index} |
| fill_way | input | WAY_W | Way written by the fill |
| fill_data | input | DATA_W | Line data written by the fill |
| resp_valid | output | 1 | Response is final this cycle |
| resp_hit | output | 1 | Final response is a hit |
| resp_data | output | DATA_W | Guessed way's data, or the correct way's data on replay |
| stall | output | 1 | Wrong guess; hold the request inputs for one cycle |
| cnt_pred_hit | output | CNT_W | Count of correctly guessed hits |
| cnt_mispred | output | CNT_W | Count of wrongly guessed hits |
| cnt_miss | output | CNT_W | Count of misses |

## Verification
The assertions assume that a set never holds two valid ways with the same tag, and that no fill reaches a set while a lookup on that set is still in progress. The stimulus fills each set with distinct tags before it probes that set. It overwrites a way only while no lookup is active, and it never pulses `fill_en` in the same cycle as `req_valid`. In a wrong-guess cycle the bench sometimes drives a different request, which the design must ignore.

// File: rtl/wp_pkg.sv
// Package: shared types for the way-predicted lookup stage.
// Assumes nothing beyond being compiled before the modules that import it.
package wp_pkg;
    // How a request chooses its guessed way.
    typedef enum logic {
        PM_HISTORY = 1'b0,
        PM_PARTIAL = 1'b1
    } pred_mode_e;
endpackage

// File: rtl/wp_store.sv
// Module: wp_store
// Holds the tag, data and valid flag of every way of every set, and reads one
// whole set at a time without a clock. Only valid flags are reset. Assumes a
// fill does not target a set while a lookup on that set is in progress.
module wp_store #(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fill_en,
    input  logic [IDX_W-1:0]              fill_set,
    input  logic [WAY_W-1:0]              fill_way,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [DATA_W-1:0]             fill_data,
    input  logic [IDX_W-1:0]              rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]   rd_data,
    output logic [WAYS-1:0]               rd_valid
);
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];

    // Purpose: clear the valid flags on reset and set one on each fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    // Purpose: write the tag and data of the filled way.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][fill_way]  <= fill_tag;
            data_q[fill_set][fill_way] <= fill_data;
        end
    end

    // Purpose: present every way of the addressed set in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w]   = tag_q[rd_set][w];
        assign rd_data[w]  = data_q[rd_set][w];
        assign rd_valid[w] = valid_q[rd_set][w];
    end
endmodule

// File: rtl/wp_tagcmp.sv
// Module: wp_tagcmp
// Compares the full request tag with every valid way of a set, then encodes
// the lowest hitting way. Assumes a set never holds duplicate valid tags.
module wp_tagcmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chk_en,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    input  logic [WAYS-1:0]            rd_valid,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] hit_vec;

    // Purpose: one equality comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == req_tag);
    end

    // Purpose: turn the hit vector into a way number (lowest index wins).
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit = |hit_vec;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $onehot0(hit_vec)); // R2
endmodule

// File: rtl/wp_pred.sv
// Module: wp_pred
// Produces the guessed way. In history mode it reads a table of the
// last-hitting way, indexed by set XOR low PC bits. In partial-tag mode it
// picks the lowest valid way whose low tag bits match. Every hit trains the
// table. Assumes PT_W <= TAG_W.
module wp_pred
    import wp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    parameter int PT_W  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chk_en,
    input  pred_mode_e                 mode,
    input  logic [IDX_W-1:0]           tbl_idx,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    input  logic [WAYS-1:0]            rd_valid,
    input  logic                       upd_en,
    input  logic [WAY_W-1:0]           upd_way,
    output logic [WAY_W-1:0]           pred_way
);
    logic [WAY_W-1:0] hist_q [SETS];
    logic [WAY_W-1:0] pt_way;
    logic             pt_any;

    // Purpose: history table, cleared to way 0 and trained on every hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) hist_q[s] <= '0;
        end else if (upd_en) begin
            hist_q[tbl_idx] <= upd_way;
        end
    end

    // Purpose: partial-tag preselect, lowest-numbered matching valid way.
    always_comb begin
        pt_way = '0;
        pt_any = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (rd_valid[w] && (rd_tag[w][PT_W-1:0] == req_tag[PT_W-1:0])) begin
                pt_way = WAY_W'(w);
                pt_any = 1'b1;
            end
        end
    end

    assign pred_way = (mode == PM_PARTIAL) ? pt_way : hist_q[tbl_idx];

    AST_PARTIAL_PICK_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && mode == PM_PARTIAL && pt_any) |->
            (rd_valid[pred_way] && rd_tag[pred_way][PT_W-1:0] == req_tag[PT_W-1:0])); // R6
    AST_HIST_TRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (hist_q[$past(tbl_idx)] == $past(upd_way))); // R5
endmodule

// File: rtl/wp_lookup.sv
// Module: wp_lookup (top)
// Lookup stage with a guessed way. The accepted request is registered. In the
// following cycle the guessed way's data is driven while the full compare
// runs. A wrong guess stalls one cycle and then replays the hitting way.
// Assumes the requester holds its request while stall is 1, and that no fill
// reaches the set under lookup.
module wp_lookup
    import wp_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int PT_W   = 4,
    parameter int CNT_W  = 16,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_pc,
    input  logic              req_mode,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [DATA_W-1:0] fill_data,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              stall,
    output logic [CNT_W-1:0]  cnt_pred_hit,
    output logic [CNT_W-1:0]  cnt_mispred,
    output logic [CNT_W-1:0]  cnt_miss
);
    logic                        s_valid, r_pending;
    logic [ADDR_W-1:0]           s_addr;
    logic [IDX_W-1:0]            s_pc;
    pred_mode_e                  s_mode;
    logic [WAY_W-1:0]            r_way;
    logic [IDX_W-1:0]            s_set;
    logic [TAG_W-1:0]            s_tag;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    logic [WAYS-1:0]             rd_valid;
    logic                        any_hit, mispred;
    logic [WAY_W-1:0]            hit_way, pred_way;

    assign s_set = s_addr[IDX_W-1:0];
    assign s_tag = s_addr[ADDR_W-1:IDX_W];

    wp_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_set(fill_addr[IDX_W-1:0]), .fill_way(fill_way),
        .fill_tag(fill_addr[ADDR_W-1:IDX_W]), .fill_data(fill_data),
        .rd_set(s_set), .rd_tag(rd_tag), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    wp_tagcmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .chk_en(s_valid),
        .req_tag(s_tag), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .any_hit(any_hit), .hit_way(hit_way)
    );

    wp_pred #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .PT_W(PT_W)) u_pred (
        .clk(clk), .rst_n(rst_n), .chk_en(s_valid), .mode(s_mode),
        .tbl_idx(s_set ^ s_pc), .req_tag(s_tag),
        .rd_tag(rd_tag), .rd_valid(rd_valid),
        .upd_en(s_valid && any_hit), .upd_way(hit_way),
        .pred_way(pred_way)
    );

    // Purpose: derive the response from the first or the replay cycle.
    always_comb begin
        mispred    = s_valid && any_hit && (pred_way != hit_way);
        stall      = mispred;
        resp_valid = (s_valid && !mispred) || r_pending;
        resp_hit   = r_pending || (s_valid && any_hit);
        resp_data  = r_pending ? rd_data[r_way] : rd_data[pred_way];
    end

    // Purpose: accept requests, or hold the request and schedule a replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid   <= 1'b0;
            r_pending <= 1'b0;
            s_addr    <= '0;
            s_pc      <= '0;
            s_mode    <= PM_HISTORY;
            r_way     <= '0;
        end else if (mispred) begin
            s_valid   <= 1'b0;
            r_pending <= 1'b1;
            r_way     <= hit_way;
        end else begin
            r_pending <= 1'b0;
            s_valid   <= req_valid;
            if (req_valid) begin
                s_addr <= req_addr;
                s_pc   <= req_pc;
                s_mode <= pred_mode_e'(req_mode);
            end
        end
    end

    // Purpose: count correct guesses, wrong guesses and misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_pred_hit <= '0;
            cnt_mispred  <= '0;
            cnt_miss     <= '0;
        end else if (s_valid) begin
            if (!any_hit)     cnt_miss     <= cnt_miss + 1'b1;
            else if (mispred) cnt_mispred  <= cnt_mispred + 1'b1;
            else              cnt_pred_hit <= cnt_pred_hit + 1'b1;
        end
    end

    AST_STALL_THEN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (resp_valid && resp_hit && !stall)); // R3
    AST_STALL_HIDES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !resp_valid); // R3
    AST_STALL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(s_addr)); // R8
    AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |=> (cnt_miss == $past(cnt_miss) + 1'b1)); // R7
    AST_MISS_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !any_hit) |-> (!stall && resp_valid)); // R4
endmodule

// File: tb/wp_lookup_tb.sv
`timescale 1ns/1ps
// Bench for wp_lookup. A behavioural model (arrays, integers) predicts every
// response cycle by cycle and is compared with the ports.
module wp_lookup_tb;
    localparam int WAYS = 4, SETS = 8, TAG_W = 8, DATA_W = 16, CNT_W = 16;
    localparam int IDX_W = 3, WAY_W = 2, ADDR_W = TAG_W + IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_mode = 1'b0, fill_en = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
    logic [IDX_W-1:0]  req_pc = '0;
    logic [WAY_W-1:0]  fill_way = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic resp_valid, resp_hit, stall;
    logic [DATA_W-1:0] resp_data;
    logic [CNT_W-1:0] cnt_pred_hit, cnt_mispred, cnt_miss;

    always #5 clk = ~clk;

    wp_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_pc(req_pc), .req_mode(req_mode), .fill_en(fill_en), .fill_addr(fill_addr),
        .fill_way(fill_way), .fill_data(fill_data), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_data(resp_data), .stall(stall),
        .cnt_pred_hit(cnt_pred_hit), .cnt_mispred(cnt_mispred), .cnt_miss(cnt_miss)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;
    int m_tag [SETS][WAYS];
    int m_data[SETS][WAYS];
    bit m_val [SETS][WAYS];
    int m_hist[SETS];
    int n_ok = 0, n_mis = 0, n_miss = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fill(input int set, input int way, input int tag, input int data);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = ADDR_W'((tag << IDX_W) | set);
        fill_way = WAY_W'(way); fill_data = DATA_W'(data);
        @(negedge clk);
        fill_en = 1'b0;
        m_tag[set][way] = tag; m_data[set][way] = data; m_val[set][way] = 1'b1;
    endtask

    task automatic chk_counts(input string req);
        chk(cnt_pred_hit == CNT_W'(n_ok), {req, " pred-hit count"}, cnt_pred_hit, n_ok);
        chk(cnt_mispred == CNT_W'(n_mis), {req, " mispredict count"}, cnt_mispred, n_mis);
        chk(cnt_miss == CNT_W'(n_miss), {req, " miss count"}, cnt_miss, n_miss);
    endtask

    // Drives one lookup, checks every cycle of its response, updates the model.
    task automatic lookup(input int tag, input int set, input int pc, input int mode,
                          input bit other, input string req);
        int pred, hitw, idx;
        idx = set ^ pc;
        pred = 0; hitw = -1;
        if (mode == 0) pred = m_hist[idx];
        else for (int w = WAYS - 1; w >= 0; w--)
            if (m_val[set][w] && (m_tag[set][w] % 16) == (tag % 16)) pred = w;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_val[set][w] && m_tag[set][w] == tag) hitw = w;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'((tag << IDX_W) | set);
        req_pc = IDX_W'(pc); req_mode = mode[0];
        @(posedge clk); #1;
        if (m_val[set][pred])  // R10 guessed way's data leads
            chk(resp_data == DATA_W'(m_data[set][pred]), {req, " R10 speculative data"},
                resp_data, m_data[set][pred]);
        if (hitw < 0) begin
            chk(resp_valid && !resp_hit && !stall, {req, " R4 miss response"},
                {resp_valid, resp_hit, stall}, 3'b100);
            n_miss++;
        end else if (hitw == pred) begin
            chk(resp_valid && resp_hit && !stall, {req, " R2 first-cycle hit"},
                {resp_valid, resp_hit, stall}, 3'b110);
            chk(resp_data == DATA_W'(m_data[set][hitw]), {req, " R2 hit data"},
                resp_data, m_data[set][hitw]);
            n_ok++;
        end else begin
            chk(!resp_valid && stall, {req, " R3 stall cycle"},
                {resp_valid, stall}, 2'b01);
            @(negedge clk);
            if (other) begin  // R8 this request must be ignored
                req_addr = ADDR_W'(((tag ^ 8'h5A) << IDX_W) | ((set + 1) % SETS));
                req_mode = ~req_mode;
            end else req_valid = 1'b0;
            @(posedge clk); #1;
            chk(resp_valid && resp_hit && !stall, {req, " R3 replay response"},
                {resp_valid, resp_hit, stall}, 3'b110);
            chk(resp_data == DATA_W'(m_data[set][hitw]), {req, " R3 replay data"},
                resp_data, m_data[set][hitw]);
            n_mis++;
        end
        if (hitw >= 0) m_hist[idx] = hitw;
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk(!resp_valid && !stall, {req, " R8 no further response"},
            {resp_valid, stall}, 2'b00);
        chk_counts({req, " R7"});
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_hist[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 1'b0; m_tag[s][w] = 0; m_data[s][w] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(!resp_valid && !stall, "R1 reset outputs", {resp_valid, stall}, 0);
        chk_counts("R1 reset");
        // Sets 1 and 2: distinct tags in every way.
        for (int w = 0; w < WAYS; w++) begin
            fill(1, w, 16 * w + 16 + w, 16'hA100 + w);
            fill(2, w, 16 * w + 16 + w, 16'hB200 + w);
        end
        lookup(8'h10, 1, 0, 0, 0, "R1/R5 reset history way 0");
        lookup(8'h32, 1, 0, 0, 0, "R3 wrong guess");
        lookup(8'h32, 1, 0, 0, 0, "R5 trained guess");
        lookup(8'h43, 1, 3, 0, 0, "R5 pc-hashed entry");
        lookup(8'h43, 1, 3, 0, 0, "R5 pc-hashed trained");
        lookup(8'h32, 1, 0, 0, 0, "R5 entry kept");
        lookup(8'h99, 1, 0, 0, 0, "R4 miss");
        lookup(8'h21, 2, 0, 0, 1, "R8 held during stall");
        lookup(8'h21, 2, 0, 0, 0, "R5 after replay");
        // Set 3: ways 0 and 1 share low tag nibble 5.
        fill(3, 0, 8'h15, 16'hC300); fill(3, 1, 8'h25, 16'hC301);
        fill(3, 2, 8'h37, 16'hC302); fill(3, 3, 8'h48, 16'hC303);
        lookup(8'h25, 3, 0, 1, 0, "R6 lowest partial match wrong");
        lookup(8'h15, 3, 0, 1, 0, "R6 lowest partial match right");
        lookup(8'h37, 3, 0, 1, 0, "R6 single partial match");
        lookup(8'h0C, 3, 0, 1, 0, "R6 no partial match way 0");
        lookup(8'h48, 3, 0, 0, 0, "R5 trained by partial hits");
        fill(1, 2, 8'h55, 16'hD155);
        lookup(8'h32, 1, 0, 0, 0, "R9 replaced tag misses");
        lookup(8'h55, 1, 0, 0, 0, "R9 new tag hits");
        for (int i = 0; i < 40; i++)
            lookup(16 * (i % 4) + 16 + (i % 4), 1 + (i % 2), i % 8, (i / 3) % 2,
                   i % 5 == 0, "R2/R3 mixed stream");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule